// File: doc/BRIEF.md
# Field Compression Sequencer

This block steps a video compressor through one field at a time. A host command, the vertical sync and the field parity decide when a field starts. Two completion events close the field: the end of the active area and the end of the code drain. The compression datapath and the code FIFO are not part of the block. Only their completion pulses come in.

When a command is accepted, the sequencer arms for the next VSYNC rising edge. If the frame qualifier was set with the command, it arms only for the next odd-field edge. It then compresses that field and pulses an end strobe. A field whose code is still draining when the next VSYNC arrives is treated as illegal. The sequencer then raises a data-error flag, sets a read-to-clear cause bit, and abandons the field that has just begun. If the interrupt is enabled, it also raises an interrupt and parks in a wait state until the host reads the status.

A command held high continuously re-arms the sequencer after every field. A command that is low leaves it idle.

Top module: `field_cmp_seq`

## Requirements
- R1: The state encoding on `state_o` is IDLE=0, WAIT_ACT=1, CMP=2, WAIT_ISR=3. While `rst_ni` is low, and after it is released, the state is IDLE and `end_o`, `daterr_o`, `irq_o` and `stat_o` are all 0.
- R2: In IDLE, `start_i` high at a clock edge moves the state to WAIT_ACT. `frame_i` is captured at that same edge and selects the odd-field-only start.
- R3: Without the frame qualifier, WAIT_ACT moves to CMP at the first VSYNC rising edge of either parity. A VSYNC level that stays high starts nothing.
- R4: With the frame qualifier, WAIT_ACT ignores even-field VSYNC edges (`field_odd_i`=0) and ignores `start_i`, and raises no `end_o`. It moves to CMP on an edge with `field_odd_i`=1.
- R5: In CMP, a field completes on a `code_drained_i` pulse that arrives in the same cycle as the `active_done_i` pulse or later. A drain pulse before the active-done pulse is ignored. On completion, `end_o` is high for exactly one cycle, in the cycle after the completing edge, and the state is IDLE.
- R6: A VSYNC rising edge in CMP before completion is a data error, and it wins over a completion in the same cycle. No `end_o` is issued, `daterr_o` and `stat_o` become 1, and the field that starts at that edge is never compressed.
- R7: On a data error with `irq_en_i`=1, `irq_o` rises and the state becomes WAIT_ISR. In WAIT_ISR `start_i` is ignored. A `stat_rd_i` pulse clears `irq_o` and `stat_o` and returns the state to IDLE.
- R8: On a data error with `irq_en_i`=0, `daterr_o` and `stat_o` are set, `irq_o` stays 0, and the state becomes IDLE.
- R9: `stat_o` stays set until a `stat_rd_i` pulse. `daterr_o` stays set until the next command is accepted in IDLE.
- R10: If `start_i` is low after a field ends, the state stays IDLE through later VSYNC edges.
- R11: The state enters CMP only from WAIT_ACT, so every pair of compressed fields has IDLE and WAIT_ACT between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Host start command (level) |
| frame_i | input | 1 | Start only on an odd field |
| vsync_i | input | 1 | Vertical sync level |
| field_odd_i | input | 1 | Field parity, 1 = odd |
| active_done_i | input | 1 | Pulse: active area of field compressed |
| code_drained_i | input | 1 | Pulse: compressed code fully drained |
| irq_en_i | input | 1 | Interrupt enable for data errors |
| stat_rd_i | input | 1 | Status read strobe (read-to-clear) |
| state_o | output | 2 | Current sequencer state |
| end_o | output | 1 | One-cycle field-complete strobe |
| daterr_o | output | 1 | Data error flag |
| irq_o | output | 1 | Interrupt request |
| stat_o | output | 1 | Status cause bit, data error |

## Verification
On every cycle, the assertions check these properties:
- the end strobe lasts one cycle and always marks a CMP-to-IDLE step;
- no end strobe follows a VSYNC that arrives during compression;
- CMP is entered only from WAIT_ACT on a VSYNC edge, and an odd-only wait holds through even fields;
- the interrupt implies the error flag, needs the enable, and is held for the whole of WAIT_ISR;
- a status read clears the cause bit.

Only the bench scenarios show the rest. They cover the field skipped after a late drain, the drain pulse that comes too early and is ignored, and an error against a completion in the same cycle. They also cover start held high or low across field ends, and the error flag lasting until the next command.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int unsigned STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_ACT = 2'd1,
    ST_CMP      = 2'd2,
    ST_WAIT_ISR = 2'd3
  } fcs_state_e;
endpackage

// File: rtl/fcs_edge_det.sv
module fcs_edge_det #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= '0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/fcs_fsm.sv
module fcs_fsm
  import fcs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       frame_i,
  input  logic       vs_rise_i,
  input  logic       field_odd_i,
  input  logic       active_done_i,
  input  logic       code_drained_i,
  input  logic       irq_en_i,
  input  logic       stat_rd_i,
  output fcs_state_e state_o,
  output logic       end_o,
  output logic       err_evt_o,
  output logic       start_acc_o
);
  fcs_state_e state_q, state_d;
  logic odd_only_q;
  logic act_seen_q;
  logic end_q;
  logic field_done;
  logic arm_hit;

  // drain counts only once the active area is done
  assign field_done  = (act_seen_q | active_done_i) & code_drained_i;
  assign arm_hit     = vs_rise_i & (~odd_only_q | field_odd_i);
  assign err_evt_o   = (state_q == ST_CMP) & vs_rise_i;
  assign start_acc_o = (state_q == ST_IDLE) & start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_WAIT_ACT;
      ST_WAIT_ACT: if (arm_hit) state_d = ST_CMP;
      ST_CMP: begin
        if (vs_rise_i)       state_d = irq_en_i ? ST_WAIT_ISR : ST_IDLE;
        else if (field_done) state_d = ST_IDLE;
      end
      ST_WAIT_ISR: if (stat_rd_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      odd_only_q <= 1'b0;
      act_seen_q <= 1'b0;
      end_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_acc_o) odd_only_q <= frame_i;
      if (state_q != ST_CMP)  act_seen_q <= 1'b0;
      else if (active_done_i) act_seen_q <= 1'b1;
      end_q <= (state_q == ST_CMP) & ~vs_rise_i & field_done;
    end
  end

  assign state_o = state_q;
  assign end_o   = end_q;

  assert_end_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> !end_o);

  assert_end_after_cmp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> (state_q == ST_IDLE && $past(state_q) == ST_CMP));

  assert_no_end_on_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMP && vs_rise_i) |=> !end_o);

  assert_wait_odd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_ACT && odd_only_q && !field_odd_i) |=> state_q == ST_WAIT_ACT);

  assert_cmp_entry_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMP && $past(state_q) != ST_CMP) |-> $past(state_q) == ST_WAIT_ACT);

  assert_cmp_needs_vsync_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMP && $past(state_q) == ST_WAIT_ACT) |-> $past(vs_rise_i));
endmodule

// File: rtl/fcs_irq.sv
module fcs_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_evt_i,
  input  logic irq_en_i,
  input  logic start_acc_i,
  input  logic stat_rd_i,
  output logic daterr_o,
  output logic irq_o,
  output logic stat_o
);
  logic daterr_q, irq_q, stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      daterr_q <= 1'b0;
      irq_q    <= 1'b0;
      stat_q   <= 1'b0;
    end else begin
      if (err_evt_i)        daterr_q <= 1'b1;
      else if (start_acc_i) daterr_q <= 1'b0;

      // set wins over a read in the same cycle
      if (err_evt_i)      stat_q <= 1'b1;
      else if (stat_rd_i) stat_q <= 1'b0;

      if (err_evt_i && irq_en_i) irq_q <= 1'b1;
      else if (stat_rd_i)        irq_q <= 1'b0;
    end
  end

  assign daterr_o = daterr_q;
  assign irq_o    = irq_q;
  assign stat_o   = stat_q;

  assert_irq_has_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> daterr_o);

  assert_irq_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_en_i));

  assert_rd_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !err_evt_i) |=> (!stat_o && !irq_o));
endmodule

// File: rtl/field_cmp_seq.sv
module field_cmp_seq
  import fcs_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               frame_i,
  input  logic               vsync_i,
  input  logic               field_odd_i,
  input  logic               active_done_i,
  input  logic               code_drained_i,
  input  logic               irq_en_i,
  input  logic               stat_rd_i,
  output logic [STATE_W-1:0] state_o,
  output logic               end_o,
  output logic               daterr_o,
  output logic               irq_o,
  output logic               stat_o
);
  logic       vs_rise;
  logic       err_evt;
  logic       start_acc;
  fcs_state_e state;

  fcs_edge_det #(.W(1)) u_vs_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (vsync_i),
    .rise_o (vs_rise)
  );

  fcs_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .frame_i        (frame_i),
    .vs_rise_i      (vs_rise),
    .field_odd_i    (field_odd_i),
    .active_done_i  (active_done_i),
    .code_drained_i (code_drained_i),
    .irq_en_i       (irq_en_i),
    .stat_rd_i      (stat_rd_i),
    .state_o        (state),
    .end_o          (end_o),
    .err_evt_o      (err_evt),
    .start_acc_o    (start_acc)
  );

  fcs_irq u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .err_evt_i   (err_evt),
    .irq_en_i    (irq_en_i),
    .start_acc_i (start_acc),
    .stat_rd_i   (stat_rd_i),
    .daterr_o    (daterr_o),
    .irq_o       (irq_o),
    .stat_o      (stat_o)
  );

  assign state_o = state;

  assert_isr_holds_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT_ISR) |-> irq_o);
endmodule

// File: tb/tb_field_cmp_seq.sv
module tb_field_cmp_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 31;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, frame_i = 0, vsync_i = 0, field_odd_i = 0;
  logic active_done_i = 0, code_drained_i = 0, irq_en_i = 0, stat_rd_i = 0;
  logic [1:0] state_o;
  logic end_o, daterr_o, irq_o, stat_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  field_cmp_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .frame_i(frame_i),
    .vsync_i(vsync_i), .field_odd_i(field_odd_i), .active_done_i(active_done_i),
    .code_drained_i(code_drained_i), .irq_en_i(irq_en_i), .stat_rd_i(stat_rd_i),
    .state_o(state_o), .end_o(end_o), .daterr_o(daterr_o), .irq_o(irq_o),
    .stat_o(stat_o)
  );

  // inputs {start,frame,vsync,odd,act_done,drained,irq_en,rd}, expected {state,end,daterr,irq,stat}
  localparam logic [13:0] VEC [NVEC] = '{
    {8'b1000_0000, 2'd1, 4'b0000},  // R2 accept, no frame
    {8'b0010_0000, 2'd2, 4'b0000},  // R3 even edge starts
    {8'b0000_0000, 2'd2, 4'b0000},
    {8'b0000_1000, 2'd2, 4'b0000},
    {8'b0000_0100, 2'd0, 4'b1000},  // R5 end strobe
    {8'b0000_0000, 2'd0, 4'b0000},  // R5 single cycle, R10
    {8'b0010_0000, 2'd0, 4'b0000},  // R10 idle through vsync
    {8'b1100_0000, 2'd1, 4'b0000},  // R2 frame captured
    {8'b1010_0000, 2'd1, 4'b0000},  // R4 even edge and start ignored
    {8'b0000_0000, 2'd1, 4'b0000},
    {8'b0011_0000, 2'd2, 4'b0000},  // R4 odd edge starts
    {8'b0000_0100, 2'd2, 4'b0000},  // R5 early drain ignored
    {8'b0000_1100, 2'd0, 4'b1000},  // R5 same-cycle completion
    {8'b1000_0010, 2'd1, 4'b0000},  // R11 held start re-arms via WAIT_ACT
    {8'b1010_0010, 2'd2, 4'b0000},
    {8'b1000_1010, 2'd2, 4'b0000},
    {8'b1010_0010, 2'd3, 4'b0111},  // R6 R7 late drain, irq
    {8'b1000_0010, 2'd3, 4'b0111},  // R7 start ignored in WAIT_ISR
    {8'b1000_0001, 2'd0, 4'b0100},  // R7 read clears irq/stat
    {8'b1000_0000, 2'd1, 4'b0000},  // R9 daterr cleared by accept, R6 field skipped
    {8'b1010_0000, 2'd2, 4'b0000},
    {8'b1000_1000, 2'd2, 4'b0000},
    {8'b1010_0000, 2'd0, 4'b0101},  // R8 error, irq disabled
    {8'b1000_0000, 2'd1, 4'b0001},  // R9 stat survives accept
    {8'b0000_0001, 2'd1, 4'b0000},  // R9 read clears stat
    {8'b0010_0000, 2'd2, 4'b0000},
    {8'b0000_1000, 2'd2, 4'b0000},
    {8'b0010_0100, 2'd0, 4'b0101},  // R6 vsync beats drain same cycle
    {8'b1000_0000, 2'd1, 4'b0001},
    {8'b0010_0000, 2'd2, 4'b0001},
    {8'b0000_1100, 2'd0, 4'b1001}
  };

  function automatic logic [5:0] outs();
    return {state_o, end_o, daterr_o, irq_o, stat_o};
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] v);
    @(negedge clk);
    {start_i, frame_i, vsync_i, field_odd_i, active_done_i, code_drained_i, irq_en_i, stat_rd_i} = v;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", outs(), 6'b00_0000);
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    #1;
    check("R1 after reset", outs(), 6'b00_0000);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][13:6]);
      check($sformatf("table step %0d", i), outs(), VEC[i][5:0]);
    end

    // R3: VSYNC level held high does not start compression
    drive(8'b0010_0000);
    check("R3 idle vsync high", outs(), 6'b00_0001);
    drive(8'b1010_0000);
    check("R3 accept under high vsync", outs(), 6'b01_0001);
    for (int k = 0; k < 5; k++) drive(8'b0010_0000);
    check("R3 level not edge", outs(), 6'b01_0001);
    drive(8'b0000_0000);
    drive(8'b0010_0000);
    check("R3 fresh edge", outs(), 6'b10_0001);

    // R1: reset in mid-field returns everything to idle
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset mid-field", outs(), 6'b00_0000);
    @(negedge clk);
    rst_ni = 1'b1;
    drive(8'b0000_0000);
    check("R1 idle after reset", outs(), 6'b00_0000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule